// File: doc/BRIEF.md
# Memory Error Reaction Controller

This block sits beside the ECC checkers of three on-chip memories: the packet buffer, the receive descriptor handler memory and the transmit descriptor handler memory. Each checker sends one-cycle pulses when it has fixed a corrected error or found an uncorrectable one. It tags an uncorrectable report with the kind of data that was hit. For each memory the controller keeps two saturating tallies, one for fixed errors and one for unfixable errors. It then picks a response based on the tag.

A damaged receive payload sets a flag that marks the packet now in flight as bad. The flag drops at that packet's end strobe. A damaged transmit payload sets a flag that tells the MAC to send the frame with a broken FCS. Damage to a receive or transmit descriptor, or to the descriptor cache, means the flow can no longer be trusted. The affected direction is halted and a location-specific cause bit is raised. Halts and causes are cleared only by a software reset. One enable input gates every reaction; the counters run whether or not it is set.

Top module: `mem_err_react`

## Requirements
- R1: A pulse on `corr_pulse[m]` raises memory m's corrected count by one in the next cycle. It produces no mark, FCS flag, halt or cause.
- R2: A pulse on `uncorr_pulse[m]` raises memory m's uncorrectable count by one in the next cycle. This holds whatever the tag and whatever `react_en` is.
- R3: Every count stops at 255 and stays there under further pulses.
- R4: With `react_en` high, an uncorrectable pulse tagged 0 (receive payload) sets `rx_mark` in the next cycle. `rx_eop` clears it one cycle later. When the pulse and `rx_eop` arrive in the same cycle, the flag is set.
- R5: With `react_en` high, an uncorrectable pulse tagged 1 (transmit payload) sets `tx_bad_fcs` in the next cycle. `tx_eop` clears it, and a set in the same cycle wins over the clear.
- R6: With `react_en` high, a pulse tagged 2 (receive descriptor) sets cause bit 0 and `rx_halt`. A pulse tagged 3 (transmit descriptor) sets cause bit 1 and `tx_halt`.
- R7: With `react_en` high, a pulse tagged 4 (descriptor cache) from memory 1 sets cause bit 2 and `rx_halt`. The same tag from memory 0 or 2 sets cause bit 3 and `tx_halt`.
- R8: Halts and cause bits stay set until `sw_rst`. End strobes and later changes of `react_en` do not clear them.
- R9: While `react_en` is low, no mark, FCS flag, halt or cause is set. Tags 5 to 7 never cause a reaction.
- R10: `sw_rst` clears all counts, flags, halts and causes in the next cycle. It wins over any pulse in the same cycle.
- R11: After `rst_n` is released, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_rst | input | 1 | Synchronous software reset pulse |
| react_en | input | 1 | Enables the reaction to uncorrectable errors |
| corr_pulse | input | 3 | Corrected-error pulse per memory |
| uncorr_pulse | input | 3 | Uncorrectable-error pulse per memory |
| err_loc | input | 9 | 3-bit location tag per memory, memory m at bits [3m+2:3m] |
| rx_eop | input | 1 | End of the receive packet in progress |
| tx_eop | input | 1 | End of the transmit frame in progress |
| corr_cnt | output | 24 | Corrected counts, memory m at bits [8m+7:8m] |
| uncorr_cnt | output | 24 | Uncorrectable counts, memory m at bits [8m+7:8m] |
| rx_mark | output | 1 | Mark the current receive packet as bad |
| tx_bad_fcs | output | 1 | Corrupt the FCS of the current transmit frame |
| rx_halt | output | 1 | Receive flow stopped |
| tx_halt | output | 1 | Transmit flow stopped |
| irq_cause | output | 4 | Location causes: rx descriptor, tx descriptor, rx cache, tx cache |

## Verification
The assertions assume that `sw_rst` and all pulses are synchronous to `clk`. They also assume that a tag counts only in a cycle where its memory's uncorrectable pulse is high, so tags are free to change at any other time. The stimulus changes inputs only on the falling edge. It drives random tags in every cycle, including the unused codes 5 to 7. It holds `react_en` steady for long stretches and then toggles it. It also runs a stretch of back-to-back pulses on one memory, long enough to pin its counters at the top value.

// File: rtl/mer_pkg.sv
`timescale 1ns/1ps
package mer_pkg;
  localparam int LOC_W = 3;
  localparam logic [LOC_W-1:0] LOC_RXDATA = 3'd0;
  localparam logic [LOC_W-1:0] LOC_TXDATA = 3'd1;
  localparam logic [LOC_W-1:0] LOC_RXDESC = 3'd2;
  localparam logic [LOC_W-1:0] LOC_TXDESC = 3'd3;
  localparam logic [LOC_W-1:0] LOC_DCACHE = 3'd4;
  localparam int CAUSE_W = 4;
  localparam int C_RXDESC = 0;
  localparam int C_TXDESC = 1;
  localparam int C_RXCACHE = 2;
  localparam int C_TXCACHE = 3;
endpackage

// File: rtl/mer_rst_sync.sv
`timescale 1ns/1ps
module mer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mer_sat_cnt.sv
`timescale 1ns/1ps
module mer_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  logic         q_en;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_en  = clr | (inc & (q != TOP));
    q_nxt = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R1/R2: one step per pulse below the top value
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && q != TOP) |=> q == $past(q) + 1'b1);
  // R3: pinned at the top value
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q == TOP && !clr) |=> q == TOP);
  // R10: software reset clears
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(q));
endmodule

// File: rtl/mer_react.sv
`timescale 1ns/1ps
module mer_react
  import mer_pkg::*;
#(
  parameter int NUM_MEM = 3,
  parameter int RX_MEM  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  input  logic [NUM_MEM-1:0]       unc,
  input  logic [NUM_MEM*LOC_W-1:0] loc,
  input  logic                     rx_eop,
  input  logic                     tx_eop,
  output logic                     rx_mark,
  output logic                     tx_bad_fcs,
  output logic                     rx_halt,
  output logic                     tx_halt,
  output logic [CAUSE_W-1:0]       cause
);
  logic               hit_rx, hit_tx;
  logic [CAUSE_W-1:0] cause_set;
  logic               rx_mark_nxt, tx_fcs_nxt;
  logic [CAUSE_W-1:0] cause_nxt;
  logic [LOC_W-1:0]   tag;

  always_comb begin
    hit_rx    = 1'b0;
    hit_tx    = 1'b0;
    cause_set = '0;
    tag       = '0;
    for (int m = 0; m < NUM_MEM; m++) begin
      tag = loc[m*LOC_W +: LOC_W];
      if (en && unc[m]) begin
        case (tag)
          LOC_RXDATA: hit_rx = 1'b1;
          LOC_TXDATA: hit_tx = 1'b1;
          LOC_RXDESC: cause_set[C_RXDESC] = 1'b1;
          LOC_TXDESC: cause_set[C_TXDESC] = 1'b1;
          LOC_DCACHE: begin
            if (m == RX_MEM) cause_set[C_RXCACHE] = 1'b1;
            else             cause_set[C_TXCACHE] = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rx_mark_nxt = clr ? 1'b0 : (hit_rx | (rx_mark & ~rx_eop));
    tx_fcs_nxt  = clr ? 1'b0 : (hit_tx | (tx_bad_fcs & ~tx_eop));
    cause_nxt   = clr ? '0 : (cause | cause_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mark    <= 1'b0;
      tx_bad_fcs <= 1'b0;
      cause      <= '0;
    end else begin
      rx_mark    <= rx_mark_nxt;
      tx_bad_fcs <= tx_fcs_nxt;
      cause      <= cause_nxt;
    end
  end

  assign rx_halt = cause[C_RXDESC] | cause[C_RXCACHE];
  assign tx_halt = cause[C_TXDESC] | cause[C_TXCACHE];

  // R8: halts persist until software reset
  p_rx_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !clr) |=> rx_halt);
  p_tx_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_halt && !clr) |=> tx_halt);
  // R9: nothing new while disabled
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> (cause == $past(cause)));
  p_mark_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rx_mark && !tx_bad_fcs) |=> (!rx_mark && !tx_bad_fcs));
  // R4: end strobe without a new hit drops the mark
  p_mark_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !en) |=> !rx_mark);
  // R10: software reset clears every reaction
  p_react_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cause == '0 && !rx_mark && !tx_bad_fcs));
endmodule

// File: rtl/mem_err_react.sv
`timescale 1ns/1ps
module mem_err_react
  import mer_pkg::*;
#(
  parameter int NUM_MEM = 3,
  parameter int CNT_W   = 8,
  parameter int RX_MEM  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_rst,
  input  logic                     react_en,
  input  logic [NUM_MEM-1:0]       corr_pulse,
  input  logic [NUM_MEM-1:0]       uncorr_pulse,
  input  logic [NUM_MEM*LOC_W-1:0] err_loc,
  input  logic                     rx_eop,
  input  logic                     tx_eop,
  output logic [NUM_MEM*CNT_W-1:0] corr_cnt,
  output logic [NUM_MEM*CNT_W-1:0] uncorr_cnt,
  output logic                     rx_mark,
  output logic                     tx_bad_fcs,
  output logic                     rx_halt,
  output logic                     tx_halt,
  output logic [CAUSE_W-1:0]       irq_cause
);
  logic rst_n_int;

  mer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    mer_sat_cnt #(.W(CNT_W)) u_corr (
      .clk   (clk),
      .rst_n (rst_n_int),
      .clr   (sw_rst),
      .inc   (corr_pulse[m]),
      .q     (corr_cnt[m*CNT_W +: CNT_W])
    );
    mer_sat_cnt #(.W(CNT_W)) u_unc (
      .clk   (clk),
      .rst_n (rst_n_int),
      .clr   (sw_rst),
      .inc   (uncorr_pulse[m]),
      .q     (uncorr_cnt[m*CNT_W +: CNT_W])
    );
  end

  mer_react #(.NUM_MEM(NUM_MEM), .RX_MEM(RX_MEM)) u_react (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr        (sw_rst),
    .en         (react_en),
    .unc        (uncorr_pulse),
    .loc        (err_loc),
    .rx_eop     (rx_eop),
    .tx_eop     (tx_eop),
    .rx_mark    (rx_mark),
    .tx_bad_fcs (tx_bad_fcs),
    .rx_halt    (rx_halt),
    .tx_halt    (tx_halt),
    .cause      (irq_cause)
  );

  // R1: a corrected-only cycle sets no reaction
  p_corr_silent_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (uncorr_pulse == '0 && !sw_rst) |=> (irq_cause == $past(irq_cause)));
endmodule

// File: tb/sim_mem_err_react.sv
`timescale 1ns/1ps
module sim_mem_err_react;
  localparam int N = 3;
  localparam int W = 8;
  localparam int TOPV = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0, react_en = 1'b0, rx_eop = 1'b0, tx_eop = 1'b0;
  logic [N-1:0] corr_pulse = '0, uncorr_pulse = '0;
  logic [N*3-1:0] err_loc = '0;
  logic [N*W-1:0] corr_cnt, uncorr_cnt;
  logic rx_mark, tx_bad_fcs, rx_halt, tx_halt;
  logic [3:0] irq_cause;

  always #10 clk = ~clk;

  mem_err_react u0 (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .react_en(react_en),
    .corr_pulse(corr_pulse), .uncorr_pulse(uncorr_pulse), .err_loc(err_loc),
    .rx_eop(rx_eop), .tx_eop(tx_eop), .corr_cnt(corr_cnt), .uncorr_cnt(uncorr_cnt),
    .rx_mark(rx_mark), .tx_bad_fcs(tx_bad_fcs), .rx_halt(rx_halt), .tx_halt(tx_halt),
    .irq_cause(irq_cause)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int m_cc[N], m_uc[N];
  bit m_rxm, m_txf;
  bit [3:0] m_cause;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int m = 0; m < N; m++) begin
      chk("R1/R3 corr count", int'(corr_cnt[m*W +: W]), m_cc[m]);
      chk("R2/R3 uncorr count", int'(uncorr_cnt[m*W +: W]), m_uc[m]);
    end
    chk("R4 rx_mark", int'(rx_mark), int'(m_rxm));
    chk("R5 tx_bad_fcs", int'(tx_bad_fcs), int'(m_txf));
    chk("R6/R7/R8 irq_cause", int'(irq_cause), int'(m_cause));
    chk("R6/R8 rx_halt", int'(rx_halt), int'(m_cause[0] | m_cause[2]));
    chk("R6/R8 tx_halt", int'(tx_halt), int'(m_cause[1] | m_cause[3]));
  endtask

  // Behavioural model: state after the coming rising edge
  task automatic model_step();
    bit set_rx, set_tx;
    set_rx = 1'b0; set_tx = 1'b0;
    if (sw_rst) begin
      for (int m = 0; m < N; m++) begin m_cc[m] = 0; m_uc[m] = 0; end
      m_rxm = 1'b0; m_txf = 1'b0; m_cause = '0;   // R10
      return;
    end
    for (int m = 0; m < N; m++) begin
      if (corr_pulse[m] && m_cc[m] < TOPV) m_cc[m]++;
      if (uncorr_pulse[m] && m_uc[m] < TOPV) m_uc[m]++;
      if (react_en && uncorr_pulse[m]) begin
        case (int'(err_loc[m*3 +: 3]))
          0: set_rx = 1'b1;
          1: set_tx = 1'b1;
          2: m_cause[0] = 1'b1;
          3: m_cause[1] = 1'b1;
          4: if (m == 1) m_cause[2] = 1'b1; else m_cause[3] = 1'b1;
          default: ;   // R9 unused tags
        endcase
      end
    end
    m_rxm = set_rx ? 1'b1 : (rx_eop ? 1'b0 : m_rxm);
    m_txf = set_tx ? 1'b1 : (tx_eop ? 1'b0 : m_txf);
  endtask

  // one cycle: compare, pick inputs, advance model
  task automatic cycle(input int p_unc, input int p_corr, input int p_rst, input bit en);
    @(negedge clk);
    compare_all();
    react_en = en;
    sw_rst   = (p_rst > 0) && ($urandom % p_rst == 0);
    rx_eop   = ($urandom % 6 == 0);
    tx_eop   = ($urandom % 6 == 0);
    for (int m = 0; m < N; m++) begin
      corr_pulse[m]   = (p_corr > 0) && ($urandom % p_corr == 0);
      uncorr_pulse[m] = (p_unc > 0) && ($urandom % p_unc == 0);
      err_loc[m*3 +: 3] = 3'($urandom % 8);
    end
    model_step();
  endtask

  task automatic directed(input logic [N-1:0] unc, input logic [8:0] loc,
                          input bit en, input bit rxe, input bit txe, input bit sr);
    @(negedge clk);
    compare_all();
    react_en = en; uncorr_pulse = unc; err_loc = loc; corr_pulse = '0;
    rx_eop = rxe; tx_eop = txe; sw_rst = sr;
    model_step();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < N; m++) begin m_cc[m] = 0; m_uc[m] = 0; end
    m_rxm = 0; m_txf = 0; m_cause = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 reset corr_cnt", int'(corr_cnt), 0);
    chk("R11 reset uncorr_cnt", int'(uncorr_cnt), 0);
    chk("R11 reset flags", int'({rx_mark, tx_bad_fcs, rx_halt, tx_halt, irq_cause}), 0);

    // R4 same-cycle set and eop on memory 0, tag 0
    directed(3'b001, 9'o000, 1'b1, 1'b1, 1'b0, 1'b0);
    directed(3'b000, 9'o000, 1'b1, 1'b1, 1'b1, 1'b0);  // R4/R5 clear
    // R5 transmit payload
    directed(3'b010, 9'o010, 1'b1, 1'b0, 1'b1, 1'b0);
    // R7 cache from memory 1 and memory 2
    directed(3'b010, 9'o040, 1'b1, 1'b0, 1'b0, 1'b0);
    directed(3'b100, 9'o400, 1'b1, 1'b0, 1'b0, 1'b0);
    // R9 disabled and unused tags
    directed(3'b111, 9'o000, 1'b0, 1'b0, 1'b0, 1'b0);
    directed(3'b111, 9'o765, 1'b1, 1'b0, 1'b0, 1'b0);
    // R10 reset wins over pulses
    directed(3'b111, 9'o234, 1'b1, 1'b0, 1'b0, 1'b1);
    directed(3'b000, 9'o000, 1'b1, 1'b0, 1'b0, 1'b0);
    // R6 descriptors then R8 persistence with enable dropped
    directed(3'b011, 9'o032, 1'b1, 1'b0, 1'b0, 1'b0);
    directed(3'b000, 9'o000, 1'b0, 1'b1, 1'b1, 1'b0);

    for (int i = 0; i < 600; i++) cycle(8, 4, 150, 1'b1);
    for (int i = 0; i < 300; i++) cycle(4, 4, 0, 1'b0);
    for (int i = 0; i < 300; i++) cycle(5, 6, 0, (i / 50) % 2 == 0);
    // R3 saturation: pulses every cycle, no software reset
    directed(3'b000, 9'o000, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 600; i++) cycle(1, 1, 0, 1'b1);
    for (int i = 0; i < 200; i++) cycle(3, 3, 40, 1'b1);
    @(negedge clk);
    compare_all();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule